// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a fully associative cache of page mappings. Every slot holds a virtual page number, an address-space identifier, a global flag, a physical frame number and a byte of attribute bits. The translation logic around it presents a page number and the current address-space identifier. In the same cycle it receives a hit flag, the slot index and the stored frame, attributes and global flag of the matching slot. A slot whose global flag is set matches under any address-space identifier. Permission checks, address assembly, fault handling and page walks belong to the surrounding logic and are not part of this block.

A single command port, sampled on the rising clock edge, handles all changes to the contents. The commands are: fill one slot, drop every mapping, drop every mapping that is not global, and drop the mappings of one page. Fills go to the slot named by a replacement pointer that steps through the slots in order. The number of slots is a parameter. It is usually set to 48 when the block serves instruction fetch and to 64 when it serves data access.

Top module: `asn_tlb`

## Requirements
- R1: After reset, every slot is invalid, every lookup misses, and the replacement pointer is 0, so the first fill lands in slot 0.
- R2: A slot hits when it is valid, its page number equals lkVpn, and either its global flag is set or its identifier equals lkAsn. On a hit, lkHit is 1 and lkIdx, lkPfn, lkAttr and lkGlobal carry the slot's index and contents. On a miss, all five outputs are 0.
- R3: A lookup is combinational on the stored state. A command changes that state only at the next rising edge, so a lookup made in the same cycle as a fill still sees the old contents.
- R4: Command code 1 (fill) writes opVpn, opAsn, opGlobal, opPfn and opAttr into the slot named by the pointer and marks it valid. The pointer then advances by one and wraps from DEPTH-1 to 0.
- R5: A fill that lands on a valid slot replaces it, and the old mapping stops hitting from the next cycle on.
- R6: Command code 2 (flush all) invalidates every slot and returns the pointer to 0.
- R7: Command code 3 (flush process) invalidates every slot whose global flag is clear and leaves global slots valid.
- R8: Command code 4 (flush page) invalidates every slot that matches opVpn and opAsn under the R2 rule. This includes global slots with any identifier. Slots that do not match are left as they are.
- R9: If more than one slot matches a lookup, the outputs report the slot with the lowest index.
- R10: Command code 0 and codes 5 to 7 change no slot and leave the pointer where it is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| lkVpn | input | VPN_W | Page number to look up |
| lkAsn | input | ASN_W | Current address-space identifier |
| lkHit | output | 1 | A valid slot matches |
| lkIdx | output | IDX_W | Index of the matching slot |
| lkPfn | output | PFN_W | Frame number of the matching slot |
| lkAttr | output | ATTR_W | Attribute bits of the matching slot |
| lkGlobal | output | 1 | Global flag of the matching slot |
| opCode | input | 3 | Command: 0 idle, 1 fill, 2 flush all, 3 flush process, 4 flush page |
| opVpn | input | VPN_W | Page number for a fill or a flush page |
| opAsn | input | ASN_W | Identifier for a fill or a flush page |
| opGlobal | input | 1 | Global flag to store on a fill |
| opPfn | input | PFN_W | Frame number to store on a fill |
| opAttr | input | ATTR_W | Attribute bits to store on a fill |

## Verification
A lookup and a fill can happen in the same cycle, and the lookup may target the very page being filled. The bench provokes this by driving the fill command and a lookup of the new page together. The lookup must miss in that cycle and then hit at the filled slot in the next cycle. The wrap case also puts a fill on top of a live slot. There, the old page must miss and the new page must hit at slot 0 right after the edge, while the neighbouring slot keeps its mapping.

// File: rtl/asn_tlb_pkg.sv
package asn_tlb_pkg;

  typedef enum logic [2:0] {
    OP_IDLE       = 3'd0,
    OP_FILL       = 3'd1,
    OP_FLUSH_ALL  = 3'd2,
    OP_FLUSH_PROC = 3'd3,
    OP_FLUSH_PAGE = 3'd4
  } tlbOp_e;

  // strobes from control to datapath, at most one set per cycle
  typedef struct packed {
    logic fill;
    logic flushAll;
    logic flushProc;
    logic flushPage;
  } tlbStrobe_t;

endpackage

// File: rtl/asn_tlb_ctrl.sv
module asn_tlb_ctrl
  import asn_tlb_pkg::*;
#(
  parameter int DEPTH = 48,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       opCode,
  output tlbStrobe_t       strobe,
  output logic [IDX_W-1:0] victimIdx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  always_comb begin
    strobe = '0;
    case (opCode)
      OP_FILL:       strobe.fill      = 1'b1;
      OP_FLUSH_ALL:  strobe.flushAll  = 1'b1;
      OP_FLUSH_PROC: strobe.flushProc = 1'b1;
      OP_FLUSH_PAGE: strobe.flushPage = 1'b1;
      default:       strobe = '0;
    endcase
  end

  // round-robin replacement pointer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      victimIdx <= '0;
    end else if (strobe.flushAll) begin
      victimIdx <= '0;
    end else if (strobe.fill) begin
      victimIdx <= (victimIdx == LAST_IDX) ? '0 : victimIdx + 1'b1;
    end
  end

endmodule

// File: rtl/asn_tlb_prio.sv
module asn_tlb_prio #(
  parameter int DEPTH = 48,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0] reqVec,
  output logic [DEPTH-1:0] grantVec,
  output logic [IDX_W-1:0] grantIdx
);

  // lowest set bit wins: scan downward so the lowest index is written last
  always_comb begin
    grantVec = '0;
    grantIdx = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (reqVec[k]) begin
        grantVec    = '0;
        grantVec[k] = 1'b1;
        grantIdx    = IDX_W'(k);
      end
    end
  end

endmodule

// File: rtl/asn_tlb_store.sv
module asn_tlb_store
  import asn_tlb_pkg::*;
#(
  parameter int DEPTH  = 48,
  parameter int VPN_W  = 27,
  parameter int ASN_W  = 8,
  parameter int PFN_W  = 27,
  parameter int ATTR_W = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tlbStrobe_t        strobe,
  input  logic [IDX_W-1:0]  victimIdx,
  input  logic [VPN_W-1:0]  lkVpn,
  input  logic [ASN_W-1:0]  lkAsn,
  input  logic [VPN_W-1:0]  opVpn,
  input  logic [ASN_W-1:0]  opAsn,
  input  logic              opGlobal,
  input  logic [PFN_W-1:0]  opPfn,
  input  logic [ATTR_W-1:0] opAttr,
  output logic              lkHit,
  output logic [IDX_W-1:0]  lkIdx,
  output logic [PFN_W-1:0]  lkPfn,
  output logic [ATTR_W-1:0] lkAttr,
  output logic              lkGlobal,
  output logic [DEPTH-1:0]  validVec,
  output logic [DEPTH-1:0]  globalVec,
  output logic [DEPTH-1:0]  lkMatchVec
);

  logic [VPN_W-1:0]  vpnArr  [DEPTH];
  logic [ASN_W-1:0]  asnArr  [DEPTH];
  logic [PFN_W-1:0]  pfnArr  [DEPTH];
  logic [ATTR_W-1:0] attrArr [DEPTH];

  logic [DEPTH-1:0] opMatchVec;
  logic [DEPTH-1:0] wrSel;
  logic [DEPTH-1:0] selVec;

  // two compare banks: one for lookups, one for page flushes
  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    logic lkSpace;
    logic opSpace;
    assign lkSpace       = globalVec[g] || (asnArr[g] == lkAsn);
    assign opSpace       = globalVec[g] || (asnArr[g] == opAsn);
    assign lkMatchVec[g] = validVec[g] && (vpnArr[g] == lkVpn) && lkSpace;
    assign opMatchVec[g] = validVec[g] && (vpnArr[g] == opVpn) && opSpace;
    assign wrSel[g]      = strobe.fill && (victimIdx == IDX_W'(g));
  end

  // valid bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      validVec <= '0;
    end else begin
      for (int k = 0; k < DEPTH; k++) begin
        if (strobe.flushAll) begin
          validVec[k] <= 1'b0;
        end else if (strobe.flushProc && !globalVec[k]) begin
          validVec[k] <= 1'b0;
        end else if (strobe.flushPage && opMatchVec[k]) begin
          validVec[k] <= 1'b0;
        end else if (wrSel[k]) begin
          validVec[k] <= 1'b1;
        end
      end
    end
  end

  // slot payload
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      globalVec <= '0;
      for (int k = 0; k < DEPTH; k++) begin
        vpnArr[k]  <= '0;
        asnArr[k]  <= '0;
        pfnArr[k]  <= '0;
        attrArr[k] <= '0;
      end
    end else begin
      for (int k = 0; k < DEPTH; k++) begin
        if (wrSel[k]) begin
          vpnArr[k]    <= opVpn;
          asnArr[k]    <= opAsn;
          pfnArr[k]    <= opPfn;
          attrArr[k]   <= opAttr;
          globalVec[k] <= opGlobal;
        end
      end
    end
  end

  asn_tlb_prio #(.DEPTH(DEPTH)) prio_i (
    .reqVec   (lkMatchVec),
    .grantVec (selVec),
    .grantIdx (lkIdx)
  );

  assign lkHit = |lkMatchVec;

  // and-or read mux over the one-hot grant; all zero on a miss
  always_comb begin
    lkPfn    = '0;
    lkAttr   = '0;
    lkGlobal = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      lkPfn    = lkPfn  | ({PFN_W{selVec[k]}}  & pfnArr[k]);
      lkAttr   = lkAttr | ({ATTR_W{selVec[k]}} & attrArr[k]);
      lkGlobal = lkGlobal | (selVec[k] & globalVec[k]);
    end
  end

endmodule

// File: rtl/asn_tlb.sv
module asn_tlb
  import asn_tlb_pkg::*;
#(
  parameter int DEPTH  = 48,
  parameter int VPN_W  = 27,
  parameter int ASN_W  = 8,
  parameter int PFN_W  = 27,
  parameter int ATTR_W = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VPN_W-1:0]  lkVpn,
  input  logic [ASN_W-1:0]  lkAsn,
  output logic              lkHit,
  output logic [IDX_W-1:0]  lkIdx,
  output logic [PFN_W-1:0]  lkPfn,
  output logic [ATTR_W-1:0] lkAttr,
  output logic              lkGlobal,
  input  logic [2:0]        opCode,
  input  logic [VPN_W-1:0]  opVpn,
  input  logic [ASN_W-1:0]  opAsn,
  input  logic              opGlobal,
  input  logic [PFN_W-1:0]  opPfn,
  input  logic [ATTR_W-1:0] opAttr
);

  tlbStrobe_t       strobe;
  logic [IDX_W-1:0] victimIdx;
  logic [DEPTH-1:0] validVec;
  logic [DEPTH-1:0] globalVec;
  logic [DEPTH-1:0] lkMatchVec;

  asn_tlb_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .opCode    (opCode),
    .strobe    (strobe),
    .victimIdx (victimIdx)
  );

  asn_tlb_store #(
    .DEPTH (DEPTH), .VPN_W (VPN_W), .ASN_W (ASN_W),
    .PFN_W (PFN_W), .ATTR_W(ATTR_W)
  ) store_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .victimIdx  (victimIdx),
    .lkVpn      (lkVpn),
    .lkAsn      (lkAsn),
    .opVpn      (opVpn),
    .opAsn      (opAsn),
    .opGlobal   (opGlobal),
    .opPfn      (opPfn),
    .opAttr     (opAttr),
    .lkHit      (lkHit),
    .lkIdx      (lkIdx),
    .lkPfn      (lkPfn),
    .lkAttr     (lkAttr),
    .lkGlobal   (lkGlobal),
    .validVec   (validVec),
    .globalVec  (globalVec),
    .lkMatchVec (lkMatchVec)
  );

endmodule

// File: rtl/asn_tlb_chk.sv
module asn_tlb_chk #(
  parameter int DEPTH = 48,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       opCode,
  input logic [IDX_W-1:0] victimIdx,
  input logic [DEPTH-1:0] validVec,
  input logic [DEPTH-1:0] globalVec,
  input logic             lkHit
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  assert_flush_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (opCode == 3'd2) |=> (validVec == '0) && (victimIdx == '0));

  assert_flush_proc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (opCode == 3'd3) |=> ((validVec & ~globalVec) == '0) &&
                         ((validVec & globalVec) == ($past(validVec) & $past(globalVec))));

  assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (opCode == 3'd1) |=> (victimIdx == (($past(victimIdx) == LAST_IDX) ? '0 : $past(victimIdx) + 1'b1)));

  assert_fill_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (opCode == 3'd1) |=> validVec[$past(victimIdx)]);

  assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((opCode == 3'd0) || (opCode > 3'd4)) |=> $stable(validVec) && $stable(victimIdx));

  assert_hit_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lkHit |-> (validVec != '0));

endmodule

bind asn_tlb asn_tlb_chk #(.DEPTH(DEPTH)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .opCode    (opCode),
  .victimIdx (victimIdx),
  .validVec  (validVec),
  .globalVec (globalVec),
  .lkHit     (lkHit)
);

// File: tb/asn_tlb_tb_top.sv
module asn_tlb_tb_top;

  localparam int DEPTH  = 48;
  localparam int VPN_W  = 27;
  localparam int ASN_W  = 8;
  localparam int PFN_W  = 27;
  localparam int ATTR_W = 8;
  localparam int IDX_W  = $clog2(DEPTH);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [VPN_W-1:0]  lkVpn = '0;
  logic [ASN_W-1:0]  lkAsn = '0;
  logic              lkHit;
  logic [IDX_W-1:0]  lkIdx;
  logic [PFN_W-1:0]  lkPfn;
  logic [ATTR_W-1:0] lkAttr;
  logic              lkGlobal;
  logic [2:0]        opCode = '0;
  logic [VPN_W-1:0]  opVpn = '0;
  logic [ASN_W-1:0]  opAsn = '0;
  logic              opGlobal = 1'b0;
  logic [PFN_W-1:0]  opPfn = '0;
  logic [ATTR_W-1:0] opAttr = '0;

  always #4 clk = ~clk;   // 125 MHz

  asn_tlb #(.DEPTH(DEPTH), .VPN_W(VPN_W), .ASN_W(ASN_W), .PFN_W(PFN_W), .ATTR_W(ATTR_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .lkVpn(lkVpn), .lkAsn(lkAsn),
    .lkHit(lkHit), .lkIdx(lkIdx), .lkPfn(lkPfn), .lkAttr(lkAttr), .lkGlobal(lkGlobal),
    .opCode(opCode), .opVpn(opVpn), .opAsn(opAsn), .opGlobal(opGlobal),
    .opPfn(opPfn), .opAttr(opAttr)
  );

  typedef struct {
    logic              hit;
    int                idx;
    logic [PFN_W-1:0]  pfn;
    logic [ATTR_W-1:0] attr;
    logic              glb;
    string             tag;
  } expItem_t;

  expItem_t sbQ[$];
  int checks = 0;
  int fails  = 0;
  int nextSlot = 0;
  bit done = 1'b0;

  // monitor: compares in the middle of the cycle the driver set up
  always @(negedge clk) begin
    if (rst_n && sbQ.size() > 0) begin
      expItem_t it;
      logic              eHit;
      logic [IDX_W-1:0]  eIdx;
      logic [PFN_W-1:0]  ePfn;
      logic [ATTR_W-1:0] eAttr;
      logic              eGlb;
      it = sbQ.pop_front();
      eHit  = it.hit;
      eIdx  = it.hit ? IDX_W'(it.idx) : '0;
      ePfn  = it.hit ? it.pfn : '0;
      eAttr = it.hit ? it.attr : '0;
      eGlb  = it.hit ? it.glb : 1'b0;
      checks++;
      if (lkHit !== eHit || lkIdx !== eIdx || lkPfn !== ePfn || lkAttr !== eAttr || lkGlobal !== eGlb) begin
        fails++;
        $display("FAIL %s: got hit=%0b idx=%0d pfn=%h attr=%h glb=%0b, expected hit=%0b idx=%0d pfn=%h attr=%h glb=%0b",
                 it.tag, lkHit, lkIdx, lkPfn, lkAttr, lkGlobal, eHit, eIdx, ePfn, eAttr, eGlb);
      end
    end
  end

  // driver: one lookup per cycle, expectation queued for the monitor
  task automatic probe(input int vpn, input int asn, input logic hit, input int idx,
                       input int pfn, input logic glb, input string tag);
    expItem_t it;
    @(posedge clk); #1;
    lkVpn = VPN_W'(vpn);
    lkAsn = ASN_W'(asn);
    it.hit = hit; it.idx = idx; it.pfn = PFN_W'(pfn);
    it.attr = ATTR_W'(vpn); it.glb = glb; it.tag = tag;
    sbQ.push_back(it);
  endtask

  task automatic issue(input int code, input int vpn, input int asn, input logic glb, input int pfn);
    @(posedge clk); #1;
    opCode = 3'(code); opVpn = VPN_W'(vpn); opAsn = ASN_W'(asn);
    opGlobal = glb; opPfn = PFN_W'(pfn); opAttr = ATTR_W'(vpn);
    @(posedge clk); #1;
    opCode = 3'd0;
  endtask

  task automatic fill(input int vpn, input int asn, input logic glb, input int pfn);
    issue(1, vpn, asn, glb, pfn);
    nextSlot = (nextSlot == DEPTH - 1) ? 0 : nextSlot + 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: empty after reset
    probe(0, 0, 0, 0, 0, 0, "R1 reset miss vpn0");
    probe('h100, 3, 0, 0, 0, 0, "R1 reset miss vpn100");

    // R1/R4: first fill lands in slot 0
    fill('h100, 3, 0, 'h11);
    probe('h100, 3, 1, 0, 'h11, 0, "R1 first fill slot0");
    probe('h100, 4, 0, 0, 0, 0, "R2 asn mismatch miss");
    probe('h101, 3, 0, 0, 0, 0, "R2 vpn mismatch miss");

    fill('h200, 5, 1, 'h22);
    probe('h200, 9, 1, 1, 'h22, 1, "R2 global ignores asn");
    fill('h300, 3, 0, 'h33);
    probe('h300, 3, 1, 2, 'h33, 0, "R4 third fill slot2");

    // R3: lookup in the fill cycle sees the old contents
    @(posedge clk); #1;
    opCode = 3'd1; opVpn = 'h400; opAsn = 1; opGlobal = 0; opPfn = 'h44; opAttr = 8'h00;
    lkVpn = 'h400; lkAsn = 1;
    sbQ.push_back('{hit:1'b0, idx:0, pfn:'0, attr:'0, glb:1'b0, tag:"R3 same-cycle fill miss"});
    @(posedge clk); #1;
    opCode = 3'd0;
    sbQ.push_back('{hit:1'b1, idx:3, pfn:PFN_W'('h44), attr:8'h00, glb:1'b0, tag:"R3 fill visible next cycle"});
    nextSlot = 4;

    // R10: unused code touches nothing
    issue(7, 'h100, 3, 0, 'h99);
    probe('h100, 3, 1, 0, 'h11, 0, "R10 code7 keeps slot0");
    fill('h500, 6, 1, 'h55);
    probe('h500, 0, 1, 4, 'h55, 1, "R10 code7 pointer unchanged");

    // R8: flush page
    issue(4, 'h100, 3, 0, 0);
    probe('h100, 3, 0, 0, 0, 0, "R8 page flushed");
    probe('h300, 3, 1, 2, 'h33, 0, "R8 other page kept");
    issue(4, 'h200, 7, 0, 0);
    probe('h200, 5, 0, 0, 0, 0, "R8 global page flushed under any asn");
    issue(4, 'h300, 9, 0, 0);
    probe('h300, 3, 1, 2, 'h33, 0, "R8 asn mismatch spares page");

    // R7: flush process
    issue(3, 0, 0, 0, 0);
    probe('h300, 3, 0, 0, 0, 0, "R7 private slot2 dropped");
    probe('h400, 1, 0, 0, 0, 0, "R7 private slot3 dropped");
    probe('h500, 0, 1, 4, 'h55, 1, "R7 global slot4 kept");

    // R9: duplicate mapping, lowest slot reported
    fill('h600, 2, 0, 'h61);
    fill('h600, 2, 0, 'h62);
    probe('h600, 2, 1, 5, 'h61, 0, "R9 lowest index wins");

    // R6: flush all
    issue(2, 0, 0, 0, 0);
    nextSlot = 0;
    probe('h500, 0, 0, 0, 0, 0, "R6 global dropped");
    probe('h600, 2, 0, 0, 0, 0, "R6 private dropped");
    fill('h700, 0, 0, 'h77);
    probe('h700, 0, 1, 0, 'h77, 0, "R6 pointer back to 0");

    // R4/R5: wrap and victim replacement
    issue(2, 0, 0, 0, 0);
    nextSlot = 0;
    for (int i = 0; i < DEPTH; i++) fill('h1000 + i, 0, 0, 'h100 + i);
    probe('h1000 + DEPTH - 1, 0, 1, DEPTH - 1, 'h100 + DEPTH - 1, 0, "R4 last slot filled");
    fill('h2000, 0, 0, 'h3AB);
    probe('h2000, 0, 1, 0, 'h3AB, 0, "R4 wrap to slot0");
    probe('h1000, 0, 0, 0, 0, 0, "R5 victim mapping dropped");
    probe('h1001, 0, 1, 1, 'h101, 0, "R5 neighbour kept");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule